// File: doc/BRIEF.md
# Weighted Exposure Metering Accumulator

This block reduces one frame of luminance samples to a single 8-bit exposure figure, which an exposure controller uses as its measured brightness. While the frame streams in, every sample is first limited to a programmable ceiling. The active area is then split into an 8 by 8 grid of regions, and one truncated average is kept for each region. Alongside this, a tracker follows the brightest and darkest horizontal running averages of the frame, taken over either 4 or 8 neighbouring samples of a line.

When the last active sample of the frame arrives, a state machine runs a short evaluation pass and leaves the incoming stream alone while it does so. The pass produces three values. The first is a row-weighted mean, in which each grid row has its own 8-bit weight and the eight weights total 256. The second is the mean of a programmable centre window of regions. The third is a mix of the result of blending those two with the peak and trough levels. The figure is published with a one-cycle strobe and then held until the next frame completes.

The states are `ST_COLLECT`, `ST_SCAN`, `ST_LAUNCH`, `ST_DIVIDE` and `ST_MIX`:

- `ST_COLLECT` waits for the frame to close, then goes to `ST_SCAN`.
- `ST_SCAN` reads one grid row per cycle. After row 7 it goes to `ST_LAUNCH`.
- `ST_LAUNCH` starts the divider, then goes to `ST_DIVIDE`.
- `ST_DIVIDE` waits until the divider is idle, then goes to `ST_MIX`.
- `ST_MIX` publishes the result and returns to `ST_COLLECT`.

Top module: `exp_meter_top`

## Requirements
- R1: After reset, `exp_value` is 0 and `exp_done` is 0.
- R2: `frame_start` opens a frame at line 0, column 0. Each later `line_start` moves to column 0 of the next line. Only a sample with `pix_valid` high, a column below ACT_W and a line below ACT_H is accepted. The frame closes on the sample at column ACT_W-1 of line ACT_H-1. Samples beyond the line width and samples after the frame has closed have no effect on the result.
- R3: Every accepted sample is replaced by `clip_ceil` when it exceeds it, before any statistic is formed. When `peak_hi_ratio + peak_lo_ratio` is at most 256, `exp_value` never exceeds `clip_ceil`.
- R4: Regions are ACT_W/8 columns wide and ACT_H/8 lines tall, with truncating division. Each region's average is its sample sum divided by the region's sample count, truncated.
- R5: Each grid row's mean is the sum of its eight region averages divided by 8, truncated. That mean is multiplied by the row's weight, where row r uses `row_wt[8r+7:8r]`. The products are summed, the sum is divided by 256, and the result saturates at 255.
- R6: Within `ctr_pos`, bits [5:3] give the window's first grid column and bits [2:0] its first grid row. Within `ctr_size`, bits [5:3] give the extra columns and bits [2:0] the extra rows. The last column and last row are each clipped to 7. The centre value is the truncated sum of the region averages inside the window divided by the number of regions in the window.
- R7: The blend is (rowval×(64−W) + centre×W)/64, truncated. W is `ctr_wt`, and any value above 64 is treated as 64.
- R8: With `peak_narrow` at 0 the window is 8 samples; with it at 1 the window is 4 samples. Each run of that many consecutive accepted samples within one line gives a truncated mean. Top is the largest such mean in the frame and starts at 0. Bottom is the smallest and starts at 255.
- R9: The result is (blend×C + top×PH + bottom×PL)/256, truncated and saturated at 255. C is 256−PH−PL, floored at 0.
- R10: `exp_done` pulses for exactly one cycle, no more than 40 cycles after the closing sample is accepted. `exp_value` changes only in that cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Opens a new frame at line 0 |
| line_start | input | 1 | Advances to the next line |
| pix_valid | input | 1 | Sample strobe |
| pix_luma | input | 8 | Luminance sample |
| clip_ceil | input | 8 | Sample ceiling |
| row_wt | input | 64 | Eight row weights, row r in bits [8r+7:8r] |
| ctr_wt | input | 7 | Centre blend weight (0 to 64) |
| ctr_pos | input | 6 | Centre window first column [5:3], first row [2:0] |
| ctr_size | input | 6 | Centre window extra columns [5:3], extra rows [2:0] |
| peak_hi_ratio | input | 8 | Share of the top level |
| peak_lo_ratio | input | 8 | Share of the bottom level |
| peak_narrow | input | 1 | 1 selects a 4-sample peak window, 0 an 8-sample window |
| exp_value | output | 8 | Exposure figure |
| exp_done | output | 1 | One-cycle strobe when a new figure is published |

## Verification
The assertions take three things for granted about the inputs. A sample strobe never shares a cycle with `line_start` or `frame_start`. The row weights add up to exactly 256 whenever a result is published. The ceiling and the mixing ratios do not change between the closing sample and the strobe. The stimulus drives strobes and samples on separate cycles and draws random weight sets whose last entry makes up the remainder to 256. It changes configuration only after the strobe of the previous frame has been seen, and it never starts a frame while an evaluation pass is still running.

// File: rtl/exp_meter_pkg.sv
package exp_meter_pkg;

    localparam int GRID = 8;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_SCAN,
        ST_LAUNCH,
        ST_DIVIDE,
        ST_MIX
    } meter_state_t;

    function automatic logic [7:0] clip_luma(input logic [7:0] v, input logic [7:0] ceil_v);
        return (v > ceil_v) ? ceil_v : v;
    endfunction

endpackage

// File: rtl/exp_grid_collect.sv
module exp_grid_collect
    import exp_meter_pkg::*;
#(
    parameter int ACT_W = 32,
    parameter int ACT_H = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                line_start,
    input  logic                pix_valid,
    input  logic [7:0]          pix,
    input  logic [2:0]          rd_row,
    output logic                pix_accept,
    output logic                frame_close,
    output logic [GRID*8-1:0]   row_avgs
);

    localparam int RW      = ACT_W / GRID;
    localparam int RH      = ACT_H / GRID;
    localparam int REG_PIX = RW * RH;
    localparam int GRID_W  = RW * GRID;
    localparam int GRID_H  = RH * GRID;
    localparam int XW      = $clog2(ACT_W + 1);
    localparam int YW      = $clog2(ACT_H + 1);
    localparam int AW      = 8 + $clog2(REG_PIX + 1);

    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic          live_q;
    logic          accept, last_px, in_grid, band_end;
    logic [2:0]    cidx, ridx;

    always_comb begin
        accept   = pix_valid && live_q && (x_q < XW'(ACT_W)) && (y_q < YW'(ACT_H));
        last_px  = accept && (x_q == XW'(ACT_W - 1)) && (y_q == YW'(ACT_H - 1));
        in_grid  = accept && (x_q < XW'(GRID_W)) && (y_q < YW'(GRID_H));
        cidx     = 3'(int'(x_q) / RW);
        ridx     = 3'(int'(y_q) / RH);
        band_end = in_grid && (x_q == XW'(GRID_W - 1)) && ((int'(y_q) % RH) == RH - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q         <= '0;
            y_q         <= '0;
            live_q      <= 1'b0;
            frame_close <= 1'b0;
        end else begin
            frame_close <= last_px;
            if (frame_start) begin
                x_q    <= '0;
                y_q    <= '0;
                live_q <= 1'b1;
            end else if (line_start && live_q) begin
                x_q <= '0;
                if (y_q < YW'(ACT_H)) y_q <= y_q + 1'b1;
            end else if (accept) begin
                x_q <= x_q + 1'b1;
                if (last_px) live_q <= 1'b0;
            end
        end
    end

    assign pix_accept = accept;

    for (genvar c = 0; c < GRID; c++) begin : g_col
        logic [AW-1:0] acc_q, acc_nxt;
        logic [7:0]    cmem [GRID];

        always_comb acc_nxt = acc_q + ((in_grid && cidx == 3'(c)) ? AW'(pix) : '0);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (frame_start) begin
                acc_q <= '0;
            end else if (band_end) begin
                cmem[ridx] <= 8'(acc_nxt / AW'(REG_PIX));
                acc_q      <= '0;
            end else if (in_grid) begin
                acc_q <= acc_nxt;
            end
        end

        assign row_avgs[c*8 +: 8] = cmem[rd_row];
    end

endmodule

// File: rtl/exp_peak_track.sv
module exp_peak_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       line_start,
    input  logic       accept,
    input  logic [7:0] pix,
    input  logic       narrow,
    output logic [7:0] peak_top,
    output logic [7:0] peak_bot
);

    localparam int HIST = 7;

    logic [7:0]  hist [HIST];
    logic [2:0]  cnt_q;
    logic [10:0] s8, s4;
    logic [7:0]  wavg;
    logic        full;

    always_comb begin
        s8 = 11'(pix);
        for (int i = 0; i < HIST; i++) s8 = s8 + 11'(hist[i]);
        s4   = 11'(pix) + 11'(hist[0]) + 11'(hist[1]) + 11'(hist[2]);
        wavg = narrow ? 8'(s4 >> 2) : 8'(s8 >> 3);
        full = narrow ? (cnt_q >= 3'd3) : (cnt_q == 3'd7);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            peak_top <= 8'h00;
            peak_bot <= 8'hFF;
            for (int i = 0; i < HIST; i++) hist[i] <= '0;
        end else if (frame_start) begin
            cnt_q    <= '0;
            peak_top <= 8'h00;
            peak_bot <= 8'hFF;
        end else if (line_start) begin
            cnt_q <= '0;
        end else if (accept) begin
            hist[0] <= pix;
            for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
            if (cnt_q != 3'd7) cnt_q <= cnt_q + 3'd1;
            if (full) begin
                if (wavg > peak_top) peak_top <= wavg;
                if (wavg < peak_bot) peak_bot <= wavg;
            end
        end
    end

endmodule

// File: rtl/exp_seq_div.sv
module exp_seq_div #(
    parameter int NW = 14,
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic [NW-1:0] quotient
);

    localparam int CW = $clog2(NW + 1);

    logic [DW:0]   rem_q, shifted;
    logic [CW-1:0] cnt_q;
    logic          ge;

    always_comb begin
        shifted = {rem_q[DW-1:0], quotient[NW-1]};
        ge      = shifted >= {1'b0, divisor};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            quotient <= '0;
            cnt_q    <= '0;
        end else if (start) begin
            rem_q    <= '0;
            quotient <= dividend;
            cnt_q    <= CW'(NW);
        end else if (cnt_q != '0) begin
            rem_q    <= ge ? (shifted - {1'b0, divisor}) : shifted;
            quotient <= {quotient[NW-2:0], ge};
            cnt_q    <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/exp_meter_top.sv
module exp_meter_top
    import exp_meter_pkg::*;
#(
    parameter int ACT_W = 32,
    parameter int ACT_H = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic        line_start,
    input  logic        pix_valid,
    input  logic [7:0]  pix_luma,
    input  logic [7:0]  clip_ceil,
    input  logic [63:0] row_wt,
    input  logic [6:0]  ctr_wt,
    input  logic [5:0]  ctr_pos,
    input  logic [5:0]  ctr_size,
    input  logic [7:0]  peak_hi_ratio,
    input  logic [7:0]  peak_lo_ratio,
    input  logic        peak_narrow,
    output logic [7:0]  exp_value,
    output logic        exp_done
);

    localparam int SW = 19;
    localparam int CS = 14;

    meter_state_t state, nxt;

    logic [7:0]        pix_c;
    logic              accept, frame_close;
    logic [GRID*8-1:0] row_avgs;
    logic [7:0]        peak_top, peak_bot, top_snap, bot_snap;
    logic [2:0]        scan_row;
    logic [SW-1:0]     wsum;
    logic [CS-1:0]     csum;
    logic              div_busy;
    logic [CS-1:0]     quotient;

    assign pix_c = clip_luma(pix_luma, clip_ceil);

    exp_grid_collect #(.ACT_W(ACT_W), .ACT_H(ACT_H)) u_grid (
        .clk, .rst_n, .frame_start, .line_start, .pix_valid,
        .pix(pix_c), .rd_row(scan_row), .pix_accept(accept),
        .frame_close, .row_avgs
    );

    exp_peak_track u_peak (
        .clk, .rst_n, .frame_start, .line_start, .accept,
        .pix(pix_c), .narrow(peak_narrow), .peak_top, .peak_bot
    );

    // row mean, weighted product, and in-window partial sum for the row being scanned
    logic [10:0] row_sum, row_csum;
    logic [7:0]  row_mean, row_w;
    logic [SW-1:0] row_prod;
    logic [2:0]  cx0, cy0, cx1, cy1;
    logic [3:0]  cx1_w, cy1_w, cw, ch;
    logic [6:0]  ccount;
    logic        row_in;

    always_comb begin
        cx0   = ctr_pos[5:3];
        cy0   = ctr_pos[2:0];
        cx1_w = {1'b0, cx0} + {1'b0, ctr_size[5:3]};
        cy1_w = {1'b0, cy0} + {1'b0, ctr_size[2:0]};
        cx1   = (cx1_w > 4'd7) ? 3'd7 : cx1_w[2:0];
        cy1   = (cy1_w > 4'd7) ? 3'd7 : cy1_w[2:0];
        cw    = {1'b0, cx1} - {1'b0, cx0} + 4'd1;
        ch    = {1'b0, cy1} - {1'b0, cy0} + 4'd1;
        ccount = 7'(cw * ch);
        row_sum  = '0;
        row_csum = '0;
        for (int c = 0; c < GRID; c++) begin
            row_sum = row_sum + 11'(row_avgs[c*8 +: 8]);
            if (3'(c) >= cx0 && 3'(c) <= cx1) row_csum = row_csum + 11'(row_avgs[c*8 +: 8]);
        end
        row_mean = 8'(row_sum >> 3);
        row_w    = row_wt[scan_row*8 +: 8];
        row_prod = SW'(row_mean) * SW'(row_w);
        row_in   = (scan_row >= cy0) && (scan_row <= cy1);
    end

    exp_seq_div #(.NW(CS), .DW(7)) u_div (
        .clk, .rst_n, .start(state == ST_LAUNCH),
        .dividend(csum), .divisor(ccount), .busy(div_busy), .quotient
    );

    // final mix
    logic [7:0]  rowval, centre, blend, final_v;
    logic [6:0]  wc;
    logic [14:0] blend_num;
    logic [8:0]  pp, coef;
    logic [19:0] mixn;

    always_comb begin
        rowval    = (wsum[SW-1:8] > 11'd255) ? 8'd255 : wsum[15:8];
        centre    = (quotient > CS'(255)) ? 8'd255 : quotient[7:0];
        wc        = (ctr_wt > 7'd64) ? 7'd64 : ctr_wt;
        blend_num = 15'(rowval) * 15'(7'd64 - wc) + 15'(centre) * 15'(wc);
        blend     = 8'(blend_num >> 6);
        pp        = 9'(peak_hi_ratio) + 9'(peak_lo_ratio);
        coef      = (pp[8]) ? 9'd0 : (9'd256 - pp);
        mixn      = 20'(blend) * 20'(coef) + 20'(top_snap) * 20'(peak_hi_ratio)
                  + 20'(bot_snap) * 20'(peak_lo_ratio);
        final_v   = (mixn[19:8] > 12'd255) ? 8'd255 : mixn[15:8];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_COLLECT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_COLLECT: if (frame_close) nxt = ST_SCAN;
            ST_SCAN:    if (scan_row == 3'd7) nxt = ST_LAUNCH;
            ST_LAUNCH:  nxt = ST_DIVIDE;
            ST_DIVIDE:  if (!div_busy) nxt = ST_MIX;
            ST_MIX:     nxt = ST_COLLECT;
            default:    nxt = ST_COLLECT;
        endcase
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_row  <= '0;
            wsum      <= '0;
            csum      <= '0;
            top_snap  <= '0;
            bot_snap  <= '0;
            exp_value <= '0;
            exp_done  <= 1'b0;
        end else begin
            exp_done <= 1'b0;
            unique case (state)
                ST_COLLECT: if (frame_close) begin
                    scan_row <= '0;
                    wsum     <= '0;
                    csum     <= '0;
                    top_snap <= peak_top;
                    bot_snap <= peak_bot;
                end
                ST_SCAN: begin
                    wsum     <= wsum + row_prod;
                    csum     <= csum + (row_in ? CS'(row_csum) : '0);
                    scan_row <= scan_row + 3'd1;
                end
                ST_MIX: begin
                    exp_value <= final_v;
                    exp_done  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/exp_meter_chk.sv
module exp_meter_chk
    import exp_meter_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         pix_valid,
    input logic         line_start,
    input logic         frame_start,
    input logic [63:0]  row_wt,
    input logic [7:0]   clip_ceil,
    input logic [7:0]   peak_hi_ratio,
    input logic [7:0]   peak_lo_ratio,
    input logic [7:0]   exp_value,
    input logic         exp_done,
    input meter_state_t state,
    input logic [2:0]   scan_row,
    input logic [7:0]   top_snap,
    input logic [7:0]   bot_snap
);

    logic [10:0] wt_total;
    logic [8:0]  ratio_total;

    always_comb begin
        wt_total = '0;
        for (int r = 0; r < 8; r++) wt_total = wt_total + 11'(row_wt[r*8 +: 8]);
        ratio_total = 9'(peak_hi_ratio) + 9'(peak_lo_ratio);
    end

    // input assumptions (R2, R5)
    a_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !(line_start || frame_start));
    a_wt_total_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exp_done |-> wt_total == 11'd256);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exp_done |=> !exp_done);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exp_done |-> $stable(exp_value));
    p_done_after_mix_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exp_done |-> $past(state) == ST_MIX);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_done && ratio_total <= 9'd256) |-> exp_value <= clip_ceil);
    p_peak_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DIVIDE |-> top_snap >= bot_snap);
    p_scan_rows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && scan_row != 3'd7) |=> state == ST_SCAN);

endmodule

bind exp_meter_top exp_meter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_start(line_start),
    .frame_start(frame_start), .row_wt(row_wt), .clip_ceil(clip_ceil),
    .peak_hi_ratio(peak_hi_ratio), .peak_lo_ratio(peak_lo_ratio),
    .exp_value(exp_value), .exp_done(exp_done), .state(state),
    .scan_row(scan_row), .top_snap(top_snap), .bot_snap(bot_snap)
);

// File: tb/sim_exp_meter_top.sv
module sim_exp_meter_top;

    localparam int BW = 32;
    localparam int BH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, line_start = 1'b0, pix_valid = 1'b0;
    logic [7:0]  pix_luma = '0;
    logic [7:0]  clip_ceil = 8'd255;
    logic [63:0] row_wt = '0;
    logic [6:0]  ctr_wt = '0;
    logic [5:0]  ctr_pos = '0, ctr_size = '0;
    logic [7:0]  peak_hi_ratio = '0, peak_lo_ratio = '0;
    logic        peak_narrow = 1'b0;
    logic [7:0]  exp_value;
    logic        exp_done;

    always #10 clk = ~clk;

    exp_meter_top #(.ACT_W(BW), .ACT_H(BH)) u0 (
        .clk, .rst_n, .frame_start, .line_start, .pix_valid, .pix_luma,
        .clip_ceil, .row_wt, .ctr_wt, .ctr_pos, .ctr_size,
        .peak_hi_ratio, .peak_lo_ratio, .peak_narrow, .exp_value, .exp_done
    );

    int fr [BH][BW];
    int n_chk = 0, n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clipv(input int v);
        return (v > int'(clip_ceil)) ? int'(clip_ceil) : v;
    endfunction

    function automatic int model();
        int rw = BW / 8, rh = BH / 8;
        int ra [8][8];
        int wsum = 0, rowval, cx0, cy0, cx1, cy1, csum = 0, cnt, centre;
        int w, blend, n, top = 0, bot = 255, coef, res;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                int s = 0;
                for (int y = 0; y < rh; y++)
                    for (int x = 0; x < rw; x++) s += clipv(fr[r*rh+y][c*rw+x]);
                ra[r][c] = s / (rw * rh);
            end
        for (int r = 0; r < 8; r++) begin
            int rs = 0;
            for (int c = 0; c < 8; c++) rs += ra[r][c];
            wsum += (rs / 8) * int'(row_wt[r*8 +: 8]);
        end
        rowval = wsum / 256;
        if (rowval > 255) rowval = 255;
        cx0 = int'(ctr_pos[5:3]);  cy0 = int'(ctr_pos[2:0]);
        cx1 = cx0 + int'(ctr_size[5:3]); if (cx1 > 7) cx1 = 7;
        cy1 = cy0 + int'(ctr_size[2:0]); if (cy1 > 7) cy1 = 7;
        for (int r = cy0; r <= cy1; r++)
            for (int c = cx0; c <= cx1; c++) csum += ra[r][c];
        cnt = (cx1 - cx0 + 1) * (cy1 - cy0 + 1);
        centre = csum / cnt;
        w = (int'(ctr_wt) > 64) ? 64 : int'(ctr_wt);
        blend = (rowval * (64 - w) + centre * w) / 64;
        n = peak_narrow ? 4 : 8;
        for (int y = 0; y < BH; y++)
            for (int x = n - 1; x < BW; x++) begin
                int s = 0;
                for (int k = 0; k < n; k++) s += clipv(fr[y][x-k]);
                if (s / n > top) top = s / n;
                if (s / n < bot) bot = s / n;
            end
        coef = 256 - int'(peak_hi_ratio) - int'(peak_lo_ratio);
        if (coef < 0) coef = 0;
        res = (blend * coef + top * int'(peak_hi_ratio) + bot * int'(peak_lo_ratio)) / 256;
        return (res > 255) ? 255 : res;
    endfunction

    task automatic set_weights_even();
        for (int r = 0; r < 8; r++) row_wt[r*8 +: 8] = 8'd32;
    endtask

    task automatic set_weights_random();
        int s = 0;
        for (int r = 0; r < 7; r++) begin
            int v = int'($urandom % 36) + 1;
            row_wt[r*8 +: 8] = 8'(v);
            s += v;
        end
        row_wt[63:56] = 8'(256 - s);
    endtask

    task automatic fill_random();
        for (int y = 0; y < BH; y++)
            for (int x = 0; x < BW; x++) fr[y][x] = int'($urandom % 256);
    endtask

    task automatic fill_regions();
        for (int y = 0; y < BH; y++)
            for (int x = 0; x < BW; x++)
                fr[y][x] = 20 * (y / 2) + 9 * (x / 4) + (x % 3) + (y % 2) * 5;
    endtask

    task automatic send_frame(input bit extra, input bit gaps);
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int y = 0; y < BH; y++) begin
            if (y > 0) begin
                line_start = 1'b1;
                @(negedge clk);
                line_start = 1'b0;
            end
            for (int x = 0; x < BW; x++) begin
                if (gaps && ($urandom % 4) == 0) begin
                    pix_valid = 1'b0;
                    @(negedge clk);
                end
                pix_valid = 1'b1;
                pix_luma  = 8'(fr[y][x]);
                @(negedge clk);
            end
            if (extra && y < BH - 1) begin
                pix_luma = 8'd255;
                @(negedge clk);
            end
            pix_valid = 1'b0;
        end
        if (extra) begin
            pix_valid = 1'b1;
            pix_luma  = 8'd255;
            repeat (3) @(negedge clk);
            pix_valid = 1'b0;
        end
    endtask

    task automatic run_frame(input string tag, input bit extra, input bit gaps);
        int exp_v, lat, v;
        exp_v = model();
        send_frame(extra, gaps);
        lat = extra ? 3 : 0;
        while (!exp_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk({tag, " value"}, int'(exp_value), exp_v);
        chk("R10 latency within 40", int'(lat <= 40), 1);
        v = int'(exp_value);
        @(negedge clk);
        chk("R10 single-cycle strobe", int'(exp_done), 0);
        repeat (4) @(negedge clk);
        chk("R10 value held", int'(exp_value), v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        set_weights_even();
        repeat (3) @(negedge clk);
        chk("R1 reset value", int'(exp_value), 0);
        chk("R1 reset strobe", int'(exp_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // uniform frame reproduces its level
        for (int y = 0; y < BH; y++) for (int x = 0; x < BW; x++) fr[y][x] = 100;
        run_frame("R4 R5 uniform", 0, 0);
        chk("R4 uniform equals 100", int'(exp_value), 100);

        // ceiling clip
        fill_random(); clip_ceil = 8'd90; ctr_wt = 7'd20;
        ctr_pos = 6'o22; ctr_size = 6'o11; peak_hi_ratio = 8'd40; peak_lo_ratio = 8'd30;
        run_frame("R3 ceiling clip", 0, 1);

        // centre only
        fill_regions(); clip_ceil = 8'd255; ctr_wt = 7'd64;
        peak_hi_ratio = 8'd0; peak_lo_ratio = 8'd0;
        run_frame("R6 centre window", 0, 0);

        // centre weight above 64 acts as 64
        fill_random(); ctr_wt = 7'd127; ctr_pos = 6'o31; ctr_size = 6'o20;
        run_frame("R7 weight clamp", 0, 0);

        // window clipped at grid edge
        fill_regions(); ctr_wt = 7'd64; ctr_pos = 6'o65; ctr_size = 6'o77;
        run_frame("R6 edge clipped window", 0, 0);

        // ratios over 256, narrow window
        fill_random(); ctr_wt = 7'd33; ctr_pos = 6'o00; ctr_size = 6'o77;
        peak_hi_ratio = 8'd200; peak_lo_ratio = 8'd150; peak_narrow = 1'b1;
        run_frame("R8 R9 saturating mix narrow", 0, 0);

        // ratios exactly 256, wide window
        fill_regions(); peak_hi_ratio = 8'd128; peak_lo_ratio = 8'd128; peak_narrow = 1'b0;
        run_frame("R8 R9 peaks only wide", 0, 0);

        // samples beyond width and after close ignored
        fill_regions(); peak_hi_ratio = 8'd60; peak_lo_ratio = 8'd20; ctr_wt = 7'd16;
        ctr_pos = 6'o12; ctr_size = 6'o33;
        run_frame("R2 ignored samples", 1, 1);

        // strongly unequal row weights
        fill_regions(); row_wt = '0; row_wt[7:0] = 8'd200; row_wt[63:56] = 8'd56;
        ctr_wt = 7'd0; peak_hi_ratio = 8'd0; peak_lo_ratio = 8'd0;
        run_frame("R5 unequal weights", 0, 0);

        for (int i = 0; i < 10; i++) begin
            fill_random();
            set_weights_random();
            clip_ceil     = 8'(128 + ($urandom % 128));
            ctr_wt        = 7'($urandom % 96);
            ctr_pos       = 6'($urandom);
            ctr_size      = 6'($urandom);
            peak_hi_ratio = 8'($urandom % 160);
            peak_lo_ratio = 8'($urandom % 160);
            peak_narrow   = 1'($urandom);
            run_frame("R4 R5 R6 R7 R8 R9 random", 0, (i % 2) == 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule